// File: doc/BRIEF.md
# Chainable Serial Shift Port with Selectable Launch Edge

This block is the serial shift path of a quad-DAC controller. A host drives a serial clock, an active-low chip-select and a data line. All three are resynchronized to the system clock. While chip-select is low, each rising edge of the serial clock shifts one bit into a 16-bit register, most significant bit first. When chip-select returns high, the block presents the assembled word with a one-cycle strobe. It also raises a flag that is set only when exactly sixteen bits arrived, so the command decoder can reject malformed frames. Decoding the word is left to that decoder.

The most significant stage of the register drives a serial data output, so several devices can share one chip-select and be chained output to input. A mode input picks the edge that launches this output. In falling mode (the default after clear) the output moves on serial-clock falling edges, which gives a lag of 16.5 clock periods. In rising mode it moves on rising edges, which gives a lag of 16 periods. In both cases the capturing edge counts as period one. While a new word is clocked in, the output replays the word written in the previous transfer, so a host can echo-check its writes. A downstream device that should not act is handed a no-operation word.

Top module: `chain_shift_port`

## Requirements
- R1: While `rst` is high, the register, `sdo`, `word_out`, `word_stb` and `word_full` are cleared to 0, and the block returns to a state where no earlier bits are held.
- R2: With `cs_n` low, each rising edge of `sclk` shifts `sdi` into the register at bit 0. After sixteen edges the first bit sits at bit 15 of `word_out`.
- R3: While `cs_n` is high, edges of `sclk` change neither the register nor `sdo`.
- R4: Each rising edge of `cs_n` produces exactly one `word_stb` pulse, one system clock wide, with `word_out` valid alongside. `word_full` is 1 only if exactly 16 bits were shifted since `cs_n` fell. 12 or 20 bits give 0.
- R5: With `mode_rise`=0, `sdo` changes only after `sclk` falling edges. The bit captured on rising edge k is driven from the falling edge that follows rising edge k+15 (a lag of 16.5 periods).
- R6: With `mode_rise`=1, `sdo` changes only after `sclk` rising edges. The bit captured on rising edge k is driven from rising edge k+15 (a lag of 16 periods).
- R7: In falling mode, over a 16-bit transfer, the values of `sdo` seen after each rising edge spell out the previous 16-bit word, MSB first.
- R8: A 16-bit word sent as two 8-bit bursts, with `sclk` paused and `cs_n` held low between them, gives the same `word_out` and `word_full` as one unbroken burst.
- R9: When a second instance takes its `sdi` from the first one's `sdo`, on the same `sclk` and `cs_n`, its word and output are those of the first instance delayed by exactly sixteen bits, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode_rise | input | 1 | Output launch edge: 0 = serial-clock falling edge, 1 = rising edge |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip-select, asynchronous |
| sdi | input | 1 | Serial data in |
| word_out | output | WIDTH | Word assembled in the last transfer |
| word_stb | output | 1 | One-cycle pulse after chip-select rises |
| word_full | output | 1 | High when the last transfer held exactly WIDTH bits |
| sdo | output | 1 | Serial data out from the most significant stage |

## Verification
The embedded properties cover the behaviour that holds every cycle. The register stays frozen while chip-select is high. The strobe never lasts two cycles. In each mode the output moves only after its own launch edge. Clear drives the outputs to zero. What the properties cannot show is the edge count of the lag, the word content and the meaning of the full flag. The bench shows these with a bit-level scoreboard over two chained instances. It covers both modes, the split burst, short and long frames, clocking with chip-select high, and a clear in the middle of the stream.

// File: rtl/chain_shift_pkg.sv
package chain_shift_pkg;

  typedef enum logic {
    LAUNCH_FALL = 1'b0,
    LAUNCH_RISE = 1'b1
  } launch_e;

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int          NB     = 3,
  parameter int          STAGES = 2,
  parameter logic [NB-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] din,
  output logic [NB-1:0] dout
);

  logic [NB-1:0] pipe_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= INIT;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/cs_edge.sv
module cs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/cs_shift_core.sv
module cs_shift_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_lvl,
  input  logic             sclk_rise,
  input  logic             sdi_lvl,
  output logic             msb_now,
  output logic             msb_next,
  output logic [WIDTH-1:0] word_out,
  output logic             word_stb,
  output logic             word_full
);

  localparam int CW = $clog2(WIDTH + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(WIDTH);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WIDTH + 1);

  logic [WIDTH-1:0] shreg_q;
  logic [WIDTH-1:0] word_q;
  logic [CW-1:0]    cnt_q;
  logic             cs_prev_q;
  logic             stb_q;
  logic             full_q;
  logic             cs_rise;

  assign cs_rise = cs_lvl & ~cs_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      word_q    <= '0;
      cnt_q     <= '0;
      cs_prev_q <= 1'b1;
      stb_q     <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      cs_prev_q <= cs_lvl;
      stb_q     <= 1'b0;
      if (!cs_lvl && sclk_rise) begin
        shreg_q <= {shreg_q[WIDTH-2:0], sdi_lvl};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_lvl) cnt_q <= '0;
      if (cs_rise) begin
        word_q <= shreg_q;
        full_q <= (cnt_q == CNT_FULL);
        stb_q  <= 1'b1;
      end
    end
  end

  assign msb_now   = shreg_q[WIDTH-1];
  assign msb_next  = shreg_q[WIDTH-2];
  assign word_out  = word_q;
  assign word_stb  = stb_q;
  assign word_full = full_q;

  a_r3_frozen_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> $stable(shreg_q))
    else $error("R3 register moved while deselected");

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q)
    else $error("R4 strobe wider than one cycle");

  a_r1_clear_outputs: assert property (@(posedge clk)
    rst |=> (word_q == '0 && !stb_q && !full_q && shreg_q == '0))
    else $error("R1 clear left state behind");

endmodule

// File: rtl/cs_dout_launch.sv
module cs_dout_launch
  import chain_shift_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  launch_e mode,
  input  logic    cs_lvl,
  input  logic    sclk_rise,
  input  logic    sclk_fall,
  input  logic    msb_now,
  input  logic    msb_next,
  output logic    sdo
);

  logic sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q <= 1'b0;
    end else if (!cs_lvl) begin
      if (mode == LAUNCH_RISE && sclk_rise)      sdo_q <= msb_next;
      else if (mode == LAUNCH_FALL && sclk_fall) sdo_q <= msb_now;
    end
  end

  assign sdo = sdo_q;

  a_r6_rise_launch_only: assert property (@(posedge clk) disable iff (rst)
    (mode == LAUNCH_RISE && !sclk_rise) |=> $stable(sdo_q))
    else $error("R6 output moved off a rising edge");

  a_r5_fall_launch_only: assert property (@(posedge clk) disable iff (rst)
    (mode == LAUNCH_FALL && !sclk_fall) |=> $stable(sdo_q))
    else $error("R5 output moved off a falling edge");

  a_r3_sdo_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> $stable(sdo_q))
    else $error("R3 output moved while deselected");

  a_r1_clear_sdo: assert property (@(posedge clk)
    rst |=> !sdo_q)
    else $error("R1 output not cleared");

endmodule

// File: rtl/chain_shift_port.sv
module chain_shift_port
  import chain_shift_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_rise,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  output logic [WIDTH-1:0] word_out,
  output logic             word_stb,
  output logic             word_full,
  output logic             sdo
);

  localparam int NB = 3;

  logic [NB-1:0] raw_in;
  logic [NB-1:0] sync_out;
  logic          sclk_lvl;
  logic          cs_lvl;
  logic          sdi_lvl;
  logic          sclk_rise;
  logic          sclk_fall;
  logic          msb_now;
  logic          msb_next;
  launch_e       mode;

  assign raw_in = {sdi, cs_n, sclk};
  assign mode   = launch_e'(mode_rise);

  cs_sync #(.NB(NB), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (sync_out)
  );

  assign sclk_lvl = sync_out[0];
  assign cs_lvl   = sync_out[1];
  assign sdi_lvl  = sync_out[2];

  cs_edge u_sclk_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sclk_lvl),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  cs_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (cs_lvl),
    .sclk_rise (sclk_rise),
    .sdi_lvl   (sdi_lvl),
    .msb_now   (msb_now),
    .msb_next  (msb_next),
    .word_out  (word_out),
    .word_stb  (word_stb),
    .word_full (word_full)
  );

  cs_dout_launch u_launch (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .cs_lvl    (cs_lvl),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .msb_now   (msb_now),
    .msb_next  (msb_next),
    .sdo       (sdo)
  );

endmodule

// File: tb/sim_chain_shift_port.sv
module sim_chain_shift_port;

  localparam int W = 16;
  localparam int NBITS = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_rise = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;

  logic [W-1:0] word0, word1;
  logic stb0, stb1, full0, full1, sdo0, sdo1;

  always #10 clk = ~clk;

  chain_shift_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .mode_rise(mode_rise), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .word_out(word0), .word_stb(stb0), .word_full(full0), .sdo(sdo0));

  chain_shift_port #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .mode_rise(mode_rise), .sclk(sclk), .cs_n(cs_n), .sdi(sdo0),
    .word_out(word1), .word_stb(stb1), .word_full(full1), .sdo(sdo1));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit sbits [NBITS];
  int n = 0;

  typedef struct packed { logic [W-1:0] w; logic f; } exp_t;
  exp_t q0 [$];
  exp_t q1 [$];

  function automatic bit sb(input int i);
    return (i < 0) ? 1'b0 : sbits[i];
  endfunction

  function automatic logic [W-1:0] win(input int last);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[W-1-i] = sb(last - (W-1) + i);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int k);
    repeat (k) @(negedge clk);
  endtask

  // driver: one chip-select frame; split>0 pauses sclk after that many bits
  task automatic xfer(input logic [31:0] data, input int nb, input int split);
    logic [W-1:0] rx0;
    logic [W-1:0] prevw;
    rx0 = '0;
    prevw = win(n - 1);
    cs_n = 1'b0;
    waitn(4);
    for (int k = 0; k < nb; k++) begin
      // before rising edge j = n: value launched after falling edge j-1
      chk(mode_rise ? "R6 u0 before rise" : "R5 u0 before rise", {31'd0, sdo0}, {31'd0, sb(n - 16)});
      chk("R9 u1 before rise", {31'd0, sdo1}, {31'd0, sb(n - 32)});
      sdi = data[nb-1-k];
      sbits[n] = data[nb-1-k];
      waitn(4);
      sclk = 1'b1;
      waitn(4);
      if (mode_rise) begin
        chk("R6 u0 after rise", {31'd0, sdo0}, {31'd0, sb(n - 15)});
        chk("R9 u1 after rise", {31'd0, sdo1}, {31'd0, sb(n - 31)});
      end else begin
        chk("R5 u0 after rise", {31'd0, sdo0}, {31'd0, sb(n - 16)});
        chk("R9 u1 after rise", {31'd0, sdo1}, {31'd0, sb(n - 32)});
        if (k < W) rx0[W-1-k] = sdo0;
      end
      sclk = 1'b0;
      n++;
      waitn(4);
      if (split > 0 && k == split - 1) waitn(12);
    end
    cs_n = 1'b1;
    q0.push_back('{w: win(n - 1), f: (nb == W)});
    q1.push_back('{w: win(n - 1 - W), f: (nb == W)});
    if (!mode_rise && nb == W) chk("R7 echo of previous word", {16'd0, rx0}, {16'd0, prevw});
    waitn(12);
  endtask

  // monitor: scoreboard for strobed words
  bit stb0_prev = 1'b0;
  bit stb1_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stb0) begin
        if (q0.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 u0 unexpected strobe actual=1 expected=0");
        end else begin
          exp_t e;
          e = q0.pop_front();
          chk("R2 u0 word", {16'd0, word0}, {16'd0, e.w});
          chk("R4 u0 full flag", {31'd0, full0}, {31'd0, e.f});
        end
      end
      if (stb1) begin
        if (q1.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 u1 unexpected strobe actual=1 expected=0");
        end else begin
          exp_t e;
          e = q1.pop_front();
          chk("R9 u1 word", {16'd0, word1}, {16'd0, e.w});
          chk("R9 u1 full flag", {31'd0, full1}, {31'd0, e.f});
        end
      end
      if (stb0 && stb0_prev) chk("R4 strobe width", 32'd2, 32'd1);
    end
    stb0_prev = stb0;
    stb1_prev = stb1;
  end

  task automatic check_cleared();
    chk("R1 sdo u0", {31'd0, sdo0}, 32'd0);
    chk("R1 sdo u1", {31'd0, sdo1}, 32'd0);
    chk("R1 word", {16'd0, word0}, 32'd0);
    chk("R1 strobe", {31'd0, stb0}, 32'd0);
    chk("R1 full", {31'd0, full0}, 32'd0);
  endtask

  initial begin
    waitn(5);
    check_cleared();
    rst = 1'b0;
    waitn(8);

    // falling-edge launch
    xfer(32'hA5C3, 16, 0);
    xfer(32'h3C96, 16, 0);
    xfer(32'h1234, 16, 8);   // R8 two bursts
    // rising-edge launch
    mode_rise = 1'b1;
    waitn(4);
    xfer(32'hBEEF, 16, 0);
    xfer(32'h0F0F, 16, 8);   // R8 in rising mode

    // R3: clock while deselected
    begin
      logic s0, s1;
      int nb;
      s0 = sdo0; s1 = sdo1; nb = n;
      for (int t = 0; t < 5; t++) begin
        sdi = t[0];
        waitn(4); sclk = 1'b1; waitn(4); sclk = 1'b0;
      end
      waitn(4);
      chk("R3 u0 sdo held", {31'd0, sdo0}, {31'd0, s0});
      chk("R3 u1 sdo held", {31'd0, sdo1}, {31'd0, s1});
      chk("R3 stream not advanced", n, nb);
    end

    xfer(32'hABC, 12, 0);    // R4 short frame
    mode_rise = 1'b0;
    waitn(4);
    xfer(32'hF00D5, 20, 0);  // R4 long frame
    xfer(32'h8001, 16, 0);
    xfer(32'h6A59, 16, 0);

    // R1 clear in the middle of the stream
    rst = 1'b1;
    waitn(3);
    check_cleared();
    rst = 1'b0;
    for (int i = 0; i < NBITS; i++) sbits[i] = 1'b0;
    waitn(8);

    xfer(32'h7E81, 16, 0);
    xfer(32'hC3A5, 16, 0);
    mode_rise = 1'b1;
    waitn(4);
    xfer(32'h55AA, 16, 0);

    waitn(10);
    chk("R4 strobes matched u0", q0.size(), 0);
    chk("R9 strobes matched u1", q1.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule